// File: doc/BRIEF.md
# Compressed-to-wide instruction expander

The block takes one 32-bit fetch word that carries two 16-bit compressed instructions. It rewrites the current one into the equivalent 32-bit wide instruction word. It does not decode into control signals. It picks a fixed wide encoding for the compressed format and moves every field into the bit position the wide format expects. Register numbers, immediates, offsets, shift types and register lists are all moved this way.

A byte-order input selects which half of the fetch word is the current instruction. The other half is passed out unchanged as the next instruction, so a later stage can pair instructions.

Each result carries a status: decoded, branch or undefined.
- Branch formats are only classified. They are not executed, and their word is zero.
- Undefined encodings produce a fixed poison word.

A parameter chooses between a purely combinational output and a one-cycle registered output. The registered output is the default.

Top module: `cx_expand`

## Requirements
- R1: With `swap_i`=0 the current instruction is `fetch_i[15:0]` and `next_o` is `fetch_i[31:16]`. With `swap_i`=1 the halves are exchanged.
- R2: Formats 0..2 (current bits [15:11]) expand to 0xE1B00000. Bits [12:11] go to [6:5], bits [10:6] to [11:7], bits [5:3] to [3:0] and bits [2:0] to [15:12].
- R3: Format 3 selects a base with bits [10:9]: 0 gives 0xE0900000, 1 gives 0xE0500000, 2 gives 0xE2900000 and 3 gives 0xE2500000. Bits [8:6] go to [2:0], bits [5:3] to [19:16] and bits [2:0] to [15:12].
- R4: Formats 4..7 select a base with bits [12:11]: 0xE3B00000, 0xE3500000, 0xE2900000 or 0xE2500000. Bits [7:0] go to [7:0], and bits [10:8] go to both [19:16] and [15:12].
- R5: Format 8 with bit 10 clear indexes a 16-entry table with bits [9:6]. The table gives the base and one of four operand placements; call d = bits [2:0] and s = bits [5:3].
  - plain: d goes to [19:16] and [15:12], s to [3:0].
  - register shift (entries 2, 3, 4, 7): d goes to [15:12] and [3:0], s to [11:8].
  - negate (entry 9): d goes to [15:12], s to [19:16].
  - multiply (entry 13): d goes to [19:16] and [11:8], s to [3:0].
- R6: Format 8 with bit 10 set forms D = {bit7, bits[2:0]} and S = {bit6, bits[5:3]}.
  - Sub-ops (bits [9:6]) 1..3, 5..7 and 9..11 use bases 0xE0800000, 0xE1500000 and 0xE1A00000 respectively. D goes to [19:16] and [15:12], S to [3:0].
  - Sub-ops 12 and 13 give 0xE12FFF10 with bits [6:3] at [3:0].
  - Sub-ops 0, 4, 8, 14 and 15 are undefined.
- R7: PC- and SP-relative forms.
  - Format 9 gives 0xE59F0000.
  - Formats 18 and 19 give 0xE58D0000 or 0xE59D0000 (bit 11 selects the load). In both cases bits [10:8] go to [15:12] and bits [7:0]×4 go to [9:2].
  - Formats 20 and 21 give 0xE28F0F00 or 0xE28D0F00 (bit 11 picks SP), with bits [10:8] at [15:12] and the raw bits [7:0] at [7:0].
  - Formats 22 and 23 with bits [11:8]=0 give 0xE28DDF00, or 0xE24DDF00 when bit 7 is set, with bits [6:0] at [6:0].
- R8: Formats 10 and 11 place bits [2:0] at [15:12], bits [5:3] at [19:16] and bits [8:6] at [2:0]. The base is indexed by bits [11:10].
  - With bit 9 clear: 0xE7800000, 0xE7C00000, 0xE7900000, 0xE7D00000.
  - With bit 9 set: 0xE18000B0, 0xE19000D0, 0xE19000B0, 0xE19000F0.
- R9: Immediate-offset transfers.
  - Formats 12..15 use bases 0xE5800000, 0xE5900000, 0xE5C00000 and 0xE5D00000, indexed by bits [12:11]. The 5-bit offset in bits [10:6] is scaled by 4 when bit 12 is clear and unscaled when bit 12 is set.
  - Formats 16 and 17 use 0xE1C000B0, or 0xE1D000B0 when bit 11 is set. Bits [8:6] go to [3:1] and bits [10:9] go to [9:8].
  - In both groups bits [2:0] go to [15:12] and bits [5:3] go to [19:16].
- R10: Multiple transfers.
  - Formats 22 and 23 with bits [11:8]≠0 index {bit11, bit8} into 0xE92D0000, 0xE92D4000, 0xE8BD0000 and 0xE8BD8000, and OR in bits [7:0].
  - Formats 24 and 25 give 0xE8A00000, or 0xE8B00000 when bit 11 is set, with bits [10:8] at [18:16] and bits [7:0] at [7:0].
- R11: Formats 26 and 27 depend on bits [11:8].
  - Bits [11:8]=0xF is decoded as 0xEF000000 with the 8-bit comment at [23:16] when it equals 0x18, and at [7:0] otherwise.
  - Bits [11:8]=0xE is undefined.
  - Every other value is a branch.
  - Formats 28, 30 and 31 are branches, and format 29 is undefined.
- R12: `kind_o` is 0 for decoded, 1 for branch and 2 for undefined, and never 3. An undefined result carries the word `POISON`, and a branch carries the word 0.
- R13: With `REG_OUT`=1, outputs follow inputs one clock later. In reset, `kind_o`=2, `wide_o`=`POISON` and `next_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_i | input | 1 | Byte order: 1 takes the current instruction from the upper half |
| fetch_i | input | 32 | Fetch word holding two compressed instructions |
| wide_o | output | 32 | Expanded wide instruction word |
| kind_o | output | 2 | Status: 0 decoded, 1 branch, 2 undefined |
| next_o | output | 16 | The other half of the fetch word |

## Verification
The hardest cases to reach are the narrow undefined holes:
- the five high-register sub-op codes,
- the condition value 0xE inside the branch/interrupt formats,
- the one interrupt comment 0x18 that moves to a different field.

Uniform random 16-bit words reach them only rarely. The bench therefore adds directed words for each hole, and for each scaling case of the immediate offsets, in both byte orders. About two thousand random words with random byte order then cover the table-driven placements against a reference function in the bench.

// File: rtl/cx_expand.sv
module cx_expand #(
  parameter bit          REG_OUT = 1'b1,
  parameter logic [31:0] POISON  = 32'h0BAD_F00D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swap_i,
  input  logic [31:0] fetch_i,
  output logic [31:0] wide_o,
  output logic [1:0]  kind_o,
  output logic [15:0] next_o
);
  localparam logic [1:0] K_DEC = 2'd0;
  localparam logic [1:0] K_BR  = 2'd1;
  localparam logic [1:0] K_UND = 2'd2;

  logic [15:0] cur, nxt;
  logic [4:0]  op;
  logic [2:0]  rl, rm, rh;
  logic [3:0]  dh, sh;
  logic [31:0] alu_base, w, w_fin;
  logic [1:0]  alu_pl, k;

  assign cur = swap_i ? fetch_i[31:16] : fetch_i[15:0];
  assign nxt = swap_i ? fetch_i[15:0]  : fetch_i[31:16];
  assign op  = cur[15:11];
  assign rl  = cur[2:0];
  assign rm  = cur[5:3];
  assign rh  = cur[10:8];
  assign dh  = {cur[7], cur[2:0]};
  assign sh  = {cur[6], cur[5:3]};

  // register ALU table: placement 0 plain, 1 shift, 2 negate, 3 multiply
  always_comb begin
    alu_pl = 2'd0;
    case (cur[9:6])
      4'd0:  alu_base = 32'hE0100000;
      4'd1:  alu_base = 32'hE0300000;
      4'd2:  begin alu_base = 32'hE1B00010; alu_pl = 2'd1; end
      4'd3:  begin alu_base = 32'hE1B00030; alu_pl = 2'd1; end
      4'd4:  begin alu_base = 32'hE1B00050; alu_pl = 2'd1; end
      4'd5:  alu_base = 32'hE0B00000;
      4'd6:  alu_base = 32'hE0D00000;
      4'd7:  begin alu_base = 32'hE1B00070; alu_pl = 2'd1; end
      4'd8:  alu_base = 32'hE1100000;
      4'd9:  begin alu_base = 32'hE2700000; alu_pl = 2'd2; end
      4'd10: alu_base = 32'hE1500000;
      4'd11: alu_base = 32'hE1700000;
      4'd12: alu_base = 32'hE1900000;
      4'd13: begin alu_base = 32'hE0100090; alu_pl = 2'd3; end
      4'd14: alu_base = 32'hE1D00000;
      default: alu_base = 32'hE1F00000;
    endcase
  end

  always_comb begin
    w = 32'h0;
    k = K_DEC;
    case (op)
      5'd0, 5'd1, 5'd2:
        w = 32'hE1B00000 | (32'(cur[12:11]) << 5) | (32'(cur[10:6]) << 7)
          | 32'(rm) | (32'(rl) << 12);
      5'd3: begin
        case (cur[10:9])
          2'd0: w = 32'hE0900000;
          2'd1: w = 32'hE0500000;
          2'd2: w = 32'hE2900000;
          default: w = 32'hE2500000;
        endcase
        w = w | 32'(cur[8:6]) | (32'(rm) << 16) | (32'(rl) << 12);
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        case (cur[12:11])
          2'd0: w = 32'hE3B00000;
          2'd1: w = 32'hE3500000;
          2'd2: w = 32'hE2900000;
          default: w = 32'hE2500000;
        endcase
        w = w | 32'(cur[7:0]) | (32'(rh) << 16) | (32'(rh) << 12);
      end
      5'd8:
        if (!cur[10]) begin
          case (alu_pl)
            2'd0: w = alu_base | (32'(rl) << 16) | (32'(rl) << 12) | 32'(rm);
            2'd1: w = alu_base | (32'(rl) << 12) | 32'(rl) | (32'(rm) << 8);
            2'd2: w = alu_base | (32'(rl) << 12) | (32'(rm) << 16);
            default: w = alu_base | (32'(rl) << 16) | (32'(rl) << 8) | 32'(rm);
          endcase
        end else begin
          case (cur[9:6])
            4'd1, 4'd2, 4'd3:
              w = 32'hE0800000 | (32'(dh) << 16) | (32'(dh) << 12) | 32'(sh);
            4'd5, 4'd6, 4'd7:
              w = 32'hE1500000 | (32'(dh) << 16) | (32'(dh) << 12) | 32'(sh);
            4'd9, 4'd10, 4'd11:
              w = 32'hE1A00000 | (32'(dh) << 16) | (32'(dh) << 12) | 32'(sh);
            4'd12, 4'd13:
              w = 32'hE12FFF10 | 32'(cur[6:3]);
            default: k = K_UND;
          endcase
        end
      5'd9:
        w = 32'hE59F0000 | (32'(rh) << 12) | (32'(cur[7:0]) << 2);
      5'd10, 5'd11: begin
        case ({cur[9], cur[11:10]})
          3'b000: w = 32'hE7800000;
          3'b001: w = 32'hE7C00000;
          3'b010: w = 32'hE7900000;
          3'b011: w = 32'hE7D00000;
          3'b100: w = 32'hE18000B0;
          3'b101: w = 32'hE19000D0;
          3'b110: w = 32'hE19000B0;
          default: w = 32'hE19000F0;
        endcase
        w = w | (32'(rl) << 12) | (32'(rm) << 16) | 32'(cur[8:6]);
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        case (cur[12:11])
          2'd0: w = 32'hE5800000;
          2'd1: w = 32'hE5900000;
          2'd2: w = 32'hE5C00000;
          default: w = 32'hE5D00000;
        endcase
        w = w | (32'(rl) << 12) | (32'(rm) << 16)
          | (cur[12] ? 32'(cur[10:6]) : (32'(cur[10:6]) << 2));
      end
      5'd16, 5'd17:
        w = (cur[11] ? 32'hE1D000B0 : 32'hE1C000B0) | (32'(rl) << 12)
          | (32'(rm) << 16) | (32'(cur[8:6]) << 1) | (32'(cur[10:9]) << 8);
      5'd18, 5'd19:
        w = (cur[11] ? 32'hE59D0000 : 32'hE58D0000) | (32'(rh) << 12)
          | (32'(cur[7:0]) << 2);
      5'd20, 5'd21:
        w = (cur[11] ? 32'hE28D0F00 : 32'hE28F0F00) | (32'(rh) << 12)
          | 32'(cur[7:0]);
      5'd22, 5'd23:
        if (cur[11:8] == 4'h0)
          w = (cur[7] ? 32'hE24DDF00 : 32'hE28DDF00) | 32'(cur[6:0]);
        else begin
          case ({cur[11], cur[8]})
            2'd0: w = 32'hE92D0000;
            2'd1: w = 32'hE92D4000;
            2'd2: w = 32'hE8BD0000;
            default: w = 32'hE8BD8000;
          endcase
          w = w | 32'(cur[7:0]);
        end
      5'd24, 5'd25:
        w = (cur[11] ? 32'hE8B00000 : 32'hE8A00000) | (32'(rh) << 16)
          | 32'(cur[7:0]);
      5'd26, 5'd27:
        if (cur[11:8] == 4'hF)
          w = 32'hEF000000 | ((cur[7:0] == 8'h18) ? (32'(cur[7:0]) << 16)
                                                   : 32'(cur[7:0]));
        else if (cur[11:8] == 4'hE) k = K_UND;
        else k = K_BR;
      5'd29:   k = K_UND;
      default: k = K_BR;
    endcase
  end

  assign w_fin = (k == K_UND) ? POISON : (k == K_BR) ? 32'h0 : w;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wide_o <= POISON;
          kind_o <= K_UND;
          next_o <= 16'h0;
        end else begin
          wide_o <= w_fin;
          kind_o <= k;
          next_o <= nxt;
        end

      // R1
      next_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> next_o == $past(swap_i ? fetch_i[15:0] : fetch_i[31:16]));
      // R11
      hole_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 5'd29) |=> kind_o == K_UND);
      // R13
      lat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(fetch_i) && $stable(swap_i) |=> $stable(wide_o));
    end else begin : g_comb
      assign wide_o = w_fin;
      assign kind_o = k;
      assign next_o = nxt;
    end
  endgenerate

  // R12
  poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == K_UND) |-> (wide_o == POISON));
  // R12
  branch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o == K_BR) |-> (wide_o == 32'h0));
  // R12
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind_o != 2'd3);
endmodule

// File: tb/cx_expand_bench.sv
`timescale 1ns/1ps
module cx_expand_bench;
  localparam logic [31:0] PZN = 32'h0BAD_F00D;
  logic clk = 1'b0, rst_n = 1'b0, swap = 1'b0;
  logic [31:0] fetch = 32'h0;
  logic [31:0] wide;
  logic [1:0]  kind;
  logic [15:0] nxt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cx_expand u_cx_expand (.clk(clk), .rst_n(rst_n), .swap_i(swap), .fetch_i(fetch),
                         .wide_o(wide), .kind_o(kind), .next_o(nxt));

  function automatic string tag_of(input logic [15:0] t);
    case (t[15:11])
      5'd0, 5'd1, 5'd2: return "R2";
      5'd3: return "R3";
      5'd4, 5'd5, 5'd6, 5'd7: return "R4";
      5'd8: return t[10] ? "R6" : "R5";
      5'd9, 5'd18, 5'd19, 5'd20, 5'd21: return "R7";
      5'd10, 5'd11: return "R8";
      5'd12, 5'd13, 5'd14, 5'd15, 5'd16, 5'd17: return "R9";
      5'd22, 5'd23: return (t[11:8] == 4'h0) ? "R7" : "R10";
      5'd24, 5'd25: return "R10";
      default: return "R11";
    endcase
  endfunction

  // returns {kind, word}
  function automatic logic [33:0] model(input logic [15:0] t);
    logic [31:0] d, s, h, base;
    logic [3:0]  sub;
    d = {29'd0, t[2:0]};
    s = {29'd0, t[5:3]};
    h = {29'd0, t[10:8]};
    sub = t[9:6];
    case (t[15:11])
      5'd0, 5'd1, 5'd2:
        return {2'd0, 32'hE1B00000 + ({30'd0, t[12:11]} * 32) + ({27'd0, t[10:6]} * 128) + s + d * 4096};
      5'd3: begin
        base = (t[10:9] == 0) ? 32'hE0900000 : (t[10:9] == 1) ? 32'hE0500000 :
               (t[10:9] == 2) ? 32'hE2900000 : 32'hE2500000;
        return {2'd0, base + {29'd0, t[8:6]} + s * 65536 + d * 4096};
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        base = (t[12:11] == 0) ? 32'hE3B00000 : (t[12:11] == 1) ? 32'hE3500000 :
               (t[12:11] == 2) ? 32'hE2900000 : 32'hE2500000;
        return {2'd0, base + {24'd0, t[7:0]} + h * 65536 + h * 4096};
      end
      5'd8:
        if (t[10] == 1'b0) begin
          case (sub)
            4'd2: return {2'd0, 32'hE1B00010 + d * 4096 + d + s * 256};
            4'd3: return {2'd0, 32'hE1B00030 + d * 4096 + d + s * 256};
            4'd4: return {2'd0, 32'hE1B00050 + d * 4096 + d + s * 256};
            4'd7: return {2'd0, 32'hE1B00070 + d * 4096 + d + s * 256};
            4'd9: return {2'd0, 32'hE2700000 + d * 4096 + s * 65536};
            4'd13: return {2'd0, 32'hE0100090 + d * 65536 + d * 256 + s};
            default: begin
              case (sub)
                4'd0: base = 32'hE0100000;  4'd1: base = 32'hE0300000;
                4'd5: base = 32'hE0B00000;  4'd6: base = 32'hE0D00000;
                4'd8: base = 32'hE1100000;  4'd10: base = 32'hE1500000;
                4'd11: base = 32'hE1700000; 4'd12: base = 32'hE1900000;
                4'd14: base = 32'hE1D00000; default: base = 32'hE1F00000;
              endcase
              return {2'd0, base + d * 65536 + d * 4096 + s};
            end
          endcase
        end else begin
          d = d + (t[7] ? 8 : 0);
          s = s + (t[6] ? 8 : 0);
          if (sub == 1 || sub == 2 || sub == 3) return {2'd0, 32'hE0800000 + d * 65536 + d * 4096 + s};
          if (sub == 5 || sub == 6 || sub == 7) return {2'd0, 32'hE1500000 + d * 65536 + d * 4096 + s};
          if (sub == 9 || sub == 10 || sub == 11) return {2'd0, 32'hE1A00000 + d * 65536 + d * 4096 + s};
          if (sub == 12 || sub == 13) return {2'd0, 32'hE12FFF10 + {28'd0, t[6:3]}};
          return {2'd2, PZN};
        end
      5'd9: return {2'd0, 32'hE59F0000 + h * 4096 + {24'd0, t[7:0]} * 4};
      5'd10, 5'd11: begin
        case ({t[9], t[11:10]})
          3'd0: base = 32'hE7800000; 3'd1: base = 32'hE7C00000;
          3'd2: base = 32'hE7900000; 3'd3: base = 32'hE7D00000;
          3'd4: base = 32'hE18000B0; 3'd5: base = 32'hE19000D0;
          3'd6: base = 32'hE19000B0; default: base = 32'hE19000F0;
        endcase
        return {2'd0, base + d * 4096 + s * 65536 + {29'd0, t[8:6]}};
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        base = (t[12:11] == 0) ? 32'hE5800000 : (t[12:11] == 1) ? 32'hE5900000 :
               (t[12:11] == 2) ? 32'hE5C00000 : 32'hE5D00000;
        return {2'd0, base + d * 4096 + s * 65536 + {27'd0, t[10:6]} * (t[12] ? 1 : 4)};
      end
      5'd16, 5'd17:
        return {2'd0, (t[11] ? 32'hE1D000B0 : 32'hE1C000B0) + d * 4096 + s * 65536
                      + {29'd0, t[8:6]} * 2 + {30'd0, t[10:9]} * 256};
      5'd18, 5'd19:
        return {2'd0, (t[11] ? 32'hE59D0000 : 32'hE58D0000) + h * 4096 + {24'd0, t[7:0]} * 4};
      5'd20, 5'd21:
        return {2'd0, (t[11] ? 32'hE28D0F00 : 32'hE28F0F00) + h * 4096 + {24'd0, t[7:0]}};
      5'd22, 5'd23:
        if (t[11:8] == 0) return {2'd0, (t[7] ? 32'hE24DDF00 : 32'hE28DDF00) + {25'd0, t[6:0]}};
        else begin
          case ({t[11], t[8]})
            2'd0: base = 32'hE92D0000; 2'd1: base = 32'hE92D4000;
            2'd2: base = 32'hE8BD0000; default: base = 32'hE8BD8000;
          endcase
          return {2'd0, base + {24'd0, t[7:0]}};
        end
      5'd24, 5'd25:
        return {2'd0, (t[11] ? 32'hE8B00000 : 32'hE8A00000) + h * 65536 + {24'd0, t[7:0]}};
      5'd26, 5'd27:
        if (t[11:8] == 4'hF)
          return {2'd0, 32'hEF000000 + ((t[7:0] == 8'h18) ? 32'h00180000 : {24'd0, t[7:0]})};
        else if (t[11:8] == 4'hE) return {2'd2, PZN};
        else return {2'd1, 32'h0};
      5'd29: return {2'd2, PZN};
      default: return {2'd1, 32'h0};
    endcase
  endfunction

  task automatic check(input string tg, input logic [49:0] act, input logic [49:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  // drive on a falling edge, one rising edge of latency (R13), sample at the next falling edge
  task automatic apply(input logic [15:0] t, input logic [15:0] other, input logic sw);
    logic [33:0] e;
    @(negedge clk);
    swap  = sw;
    fetch = sw ? {t, other} : {other, t};
    e = model(t);
    @(negedge clk);
    check(tag_of(t), {kind, wide, nxt}, {e[33:32], e[31:0], other});
    check(sw ? "R1 swap" : "R1 noswap", {34'd0, nxt}, {34'd0, other});
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] dir [0:23];
    void'($urandom(32'd20240611));
    fetch = 32'h1234_5678;
    #35;
    // R13 reset state
    check("R13 reset", {kind, wide, nxt}, {2'd2, PZN, 16'h0});
    rst_n = 1'b1;
    dir = '{16'h4400, 16'h4500, 16'h4600, 16'h4780, 16'h47C0, 16'h4740,
            16'h44FF, 16'hDF18, 16'hDF17, 16'hDE00, 16'hD0FF, 16'hE800,
            16'hE7FF, 16'hF000, 16'hF800, 16'h8FFF, 16'h7FFF, 16'h6FFF,
            16'hB080, 16'hB5FF, 16'hBDFF, 16'h4368, 16'h4268, 16'hA7FF};
    for (int i = 0; i < 24; i++) begin
      apply(dir[i], 16'hA5C3 ^ 16'(i), 1'b0);
      apply(dir[i], 16'h3C5A ^ 16'(i), 1'b1);
    end
    // R12 invariants: branch word zero, undefined word poison
    apply(16'hE000, 16'h0, 1'b0);
    check("R12 branch word", {18'd0, wide}, {18'd0, 32'h0});
    apply(16'h4400, 16'h0, 1'b1);
    check("R12 poison word", {18'd0, wide}, {18'd0, PZN});
    for (int i = 0; i < 2000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule